// File: doc/BRIEF.md
# Fault Bitmap with Spare-Bit Reuse

This block is the small associative store that sits inside a memory repair analyzer. While the memory self-test runs, the block is in test mode. Each reported failure arrives as a word address and an error syndrome. The syndrome is the XOR of the expected and the observed read data. The block splits the address into a row part and a column part, and turns a single-bit syndrome into the index of the failing bit. It keeps each distinct fault in one of a fixed number of entries and maintains a flag telling whether every fault seen so far still fits in those entries.

After analysis the block is switched to normal mode and the same entries become bit-level redundancy. Every functional access is compared with all stored rows and columns at once. When an entry matches on both row and column, the faulty bit of the word comes from that entry's spare flip-flop instead of the memory. Reads see the spare value, and writes update it. A syndrome with several bits set cannot be covered by one spare bit. Such a fault is not stored, and a separate sticky flag reports that a row or column repair is needed.

Top module: `spare_bit_bitmap`

## Requirements
- R1: After reset `repairable` is 1, `line_repair` is 0, no entry is occupied, and no access hits a spare.
- R2: In test mode, a reported fault whose syndrome has exactly one bit set is stored as an entry with the row (upper `ROW_W` bits of `flt_addr`), the column (lower `COL_W` bits) and the index of that set bit. The bit index selects the data bit that the entry later replaces.
- R3: In test mode, a fault whose syndrome has two or more bits set occupies no entry and sets `line_repair` one cycle later. `line_repair` then stays 1 until reset.
- R4: A fault whose row, column and bit index all equal those of an occupied entry is not stored again and leaves `repairable` unchanged.
- R5: A new single-bit fault that arrives in test mode while all entries are occupied clears `repairable` one cycle later, and it stays 0 until reset.
- R6: In normal mode, `spare_hit` is 1 exactly when some occupied entry has a row equal to `acc_addr[ROW_W+COL_W-1:COL_W]` and a column equal to `acc_addr[COL_W-1:0]`. A row match alone or a column match alone gives no hit.
- R7: In normal mode, `acc_rdata` equals `ram_rdata` except at the bit index of each hitting entry, where it carries that entry's spare bit. Spare bits are 0 when the entry is stored.
- R8: In normal mode, a cycle with `acc_we` = 1 writes `acc_wdata` at each hitting entry's bit index into that entry's spare bit at the clock edge.
- R9: In test mode there is no substitution: `spare_hit` is 0, `acc_rdata` equals `ram_rdata`, and `acc_we` leaves every spare bit unchanged.
- R10: Fault reports made in normal mode are ignored.
- R11: A fault report with an all-zero syndrome is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 = record faults, 0 = entries act as spare bits |
| flt_valid | input | 1 | Fault report strobe from the self-test engine |
| flt_addr | input | ROW_W+COL_W | Faulty word address, row in the upper bits |
| flt_syn | input | DATA_W | Error syndrome (expected XOR observed) |
| repairable | output | 1 | 1 while all single-bit faults fit in the entries |
| line_repair | output | 1 | Sticky: a multi-bit fault needs a row or column repair |
| acc_addr | input | ROW_W+COL_W | Functional access address |
| acc_we | input | 1 | Functional write strobe |
| acc_wdata | input | DATA_W | Functional write data |
| ram_rdata | input | DATA_W | Raw read data from the memory array |
| acc_rdata | output | DATA_W | Read data after spare-bit substitution |
| spare_hit | output | 1 | Access matches a stored entry |

## Verification
The bench sweeps every address in both modes and compares hits and substituted read data with a model of the recorded faults. A design that matched on row or column alone would light `spare_hit` on neighbours of a faulty word. Two faults on the same word at different bits must both be substituted, and a design that kept only the first match would return a wrong bit there. Duplicates and zero syndromes are sent once the table is full, so a design that stored them would drop `repairable` at that point. Fault reports are also sent in normal mode, and a design that stored them would do the same. Writes issued in test mode are later read back in normal mode, so a design that updated spares while testing would return the wrong bit. A multi-bit fault word is swept afterwards, so a design that stored it would show a hit there.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
   typedef enum logic [2:0] {
      REC_IDLE  = 3'd0,
      REC_STORE = 3'd1,
      REC_SKIP  = 3'd2,
      REC_FULL  = 3'd3,
      REC_MULTI = 3'd4
   } rec_kind_t;

   localparam logic MODE_TEST   = 1'b1;
   localparam logic MODE_NORMAL = 1'b0;
endpackage

// File: rtl/sbb_syn_enc.sv
module sbb_syn_enc #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] syn,
   output logic              any,
   output logic              multi,
   output logic [IDX_W-1:0]  idx
);
   logic found;

   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int b = 0; b < DATA_W; b++) begin
         if (syn[b] && !found) begin
            idx   = IDX_W'(b);
            found = 1'b1;
         end
      end
   end

   assign any   = |syn;
   assign multi = |(syn & (syn - DATA_W'(1)));
endmodule

// File: rtl/sbb_alloc.sv
module sbb_alloc #(
   parameter int ENTRIES = 4
) (
   input  logic [ENTRIES-1:0] occupied,
   output logic [ENTRIES-1:0] pick,
   output logic               full
);
   logic taken;

   always_comb begin
      pick  = '0;
      taken = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (!occupied[e] && !taken) begin
            pick[e] = 1'b1;
            taken   = 1'b1;
         end
      end
   end

   assign full = &occupied;
endmodule

// File: rtl/sbb_entry.sv
module sbb_entry #(
   parameter int ROW_W  = 3,
   parameter int COL_W  = 2,
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ROW_W-1:0]  ld_row,
   input  logic [COL_W-1:0]  ld_col,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [ROW_W-1:0]  cmp_row,
   input  logic [COL_W-1:0]  cmp_col,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              occupied,
   output logic              row_hit,
   output logic              col_hit,
   output logic [IDX_W-1:0]  bit_idx,
   output logic              spare
);
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occupied <= 1'b0;
         row_q    <= '0;
         col_q    <= '0;
         bit_idx  <= '0;
         spare    <= 1'b0;
      end else if (load) begin
         occupied <= 1'b1;
         row_q    <= ld_row;
         col_q    <= ld_col;
         bit_idx  <= ld_idx;
         spare    <= 1'b0;
      end else if (wr_en) begin
         spare    <= wdata[bit_idx];
      end
   end

   assign row_hit = occupied && (row_q == cmp_row);
   assign col_hit = occupied && (col_q == cmp_col);
endmodule

// File: rtl/spare_bit_bitmap.sv
module spare_bit_bitmap
   import sbb_pkg::*;
#(
   parameter int ROW_W   = 3,
   parameter int COL_W   = 2,
   parameter int DATA_W  = 8,
   parameter int ENTRIES = 4,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode,
   input  logic              flt_valid,
   input  logic [ADDR_W-1:0] flt_addr,
   input  logic [DATA_W-1:0] flt_syn,
   output logic              repairable,
   output logic              line_repair,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_we,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              spare_hit
);
   if (ROW_W < 1 || COL_W < 1) begin : g_bad_addr
      $error("spare_bit_bitmap: ROW_W and COL_W must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("spare_bit_bitmap: DATA_W must be at least 2");
   end
   if (ENTRIES < 1) begin : g_bad_depth
      $error("spare_bit_bitmap: ENTRIES must be at least 1");
   end

   logic [ADDR_W-1:0] cmp_addr;
   logic [ROW_W-1:0]  cmp_row;
   logic [COL_W-1:0]  cmp_col;
   logic              syn_any, syn_multi;
   logic [IDX_W-1:0]  syn_idx;
   logic [ENTRIES-1:0] occ, rhit, chit, same, hit, pick, load;
   logic [ENTRIES-1:0] spare_v;
   logic [IDX_W-1:0]  ent_idx [ENTRIES];
   logic              full, dup;
   rec_kind_t         rec;

   // One comparator set per entry serves both modes.
   assign cmp_addr = (test_mode == MODE_TEST) ? flt_addr : acc_addr;
   assign cmp_row  = cmp_addr[ADDR_W-1:COL_W];
   assign cmp_col  = cmp_addr[COL_W-1:0];

   sbb_syn_enc #(.DATA_W(DATA_W)) u_enc (
      .syn   (flt_syn),
      .any   (syn_any),
      .multi (syn_multi),
      .idx   (syn_idx)
   );

   sbb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
      .occupied (occ),
      .pick     (pick),
      .full     (full)
   );

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      sbb_entry #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load[e]),
         .ld_row   (cmp_row),
         .ld_col   (cmp_col),
         .ld_idx   (syn_idx),
         .cmp_row  (cmp_row),
         .cmp_col  (cmp_col),
         .wr_en    (hit[e] && acc_we),
         .wdata    (acc_wdata),
         .occupied (occ[e]),
         .row_hit  (rhit[e]),
         .col_hit  (chit[e]),
         .bit_idx  (ent_idx[e]),
         .spare    (spare_v[e])
      );
      assign same[e] = rhit[e] && chit[e] && (ent_idx[e] == syn_idx);
      assign hit[e]  = (test_mode == MODE_NORMAL) && rhit[e] && chit[e];
      assign load[e] = (rec == REC_STORE) && pick[e];
   end

   assign dup = |same;

   always_comb begin
      if (!(test_mode == MODE_TEST && flt_valid && syn_any)) rec = REC_IDLE;
      else if (syn_multi)                                   rec = REC_MULTI;
      else if (dup)                                         rec = REC_SKIP;
      else if (full)                                        rec = REC_FULL;
      else                                                  rec = REC_STORE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         repairable  <= 1'b1;
         line_repair <= 1'b0;
      end else begin
         if (rec == REC_FULL)  repairable  <= 1'b0;
         if (rec == REC_MULTI) line_repair <= 1'b1;
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic sel_v;
      always_comb begin
         sel_v = ram_rdata[b];
         for (int e = 0; e < ENTRIES; e++) begin
            if (hit[e] && ent_idx[e] == IDX_W'(b)) sel_v = spare_v[e];
         end
      end
      assign acc_rdata[b] = sel_v;
   end

   assign spare_hit = |hit;
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
   parameter int DATA_W  = 8,
   parameter int ENTRIES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              test_mode,
   input logic              flt_valid,
   input logic              repairable,
   input logic              line_repair,
   input logic              spare_hit,
   input logic [DATA_W-1:0] ram_rdata,
   input logic [DATA_W-1:0] acc_rdata
);
   assert_sticky_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      line_repair |=> line_repair);

   assert_sticky_unrepairable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !repairable |=> !repairable);

   assert_drop_needs_test_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(repairable) |-> $past(test_mode && flt_valid));

   assert_no_hit_in_test_R9: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> (!spare_hit && acc_rdata == ram_rdata));

   assert_passthru_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !spare_hit |-> acc_rdata == ram_rdata);

   assert_bounded_substitution_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(acc_rdata ^ ram_rdata) <= ENTRIES);
endmodule

bind spare_bit_bitmap sbb_checker #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_sbb_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .test_mode   (test_mode),
   .flt_valid   (flt_valid),
   .repairable  (repairable),
   .line_repair (line_repair),
   .spare_hit   (spare_hit),
   .ram_rdata   (ram_rdata),
   .acc_rdata   (acc_rdata)
);

// File: tb/spare_bit_bitmap_test.sv
`timescale 1ns/1ps
module spare_bit_bitmap_test;
   localparam int ROW_W = 3, COL_W = 2, DATA_W = 8, ENTRIES = 4;
   localparam int ADDR_W = ROW_W + COL_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic test_mode = 1'b0, flt_valid = 1'b0, acc_we = 1'b0;
   logic [ADDR_W-1:0] flt_addr = '0, acc_addr = '0;
   logic [DATA_W-1:0] flt_syn = '0, acc_wdata = '0, ram_rdata = '0;
   logic repairable, line_repair, spare_hit;
   logic [DATA_W-1:0] acc_rdata;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   int m_n = 0;
   int m_row [ENTRIES];
   int m_col [ENTRIES];
   int m_bit [ENTRIES];
   logic m_spare [ENTRIES];

   always #2.5 clk = ~clk;

   spare_bit_bitmap #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) uut (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .flt_valid(flt_valid),
      .flt_addr(flt_addr), .flt_syn(flt_syn), .repairable(repairable),
      .line_repair(line_repair), .acc_addr(acc_addr), .acc_we(acc_we),
      .acc_wdata(acc_wdata), .ram_rdata(ram_rdata), .acc_rdata(acc_rdata),
      .spare_hit(spare_hit)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [DATA_W-1:0] pat(input int a);
      return DATA_W'((a * 37 + 11) & 8'hFF);
   endfunction

   function automatic logic [DATA_W-1:0] exp_rd(input int a, input logic [DATA_W-1:0] raw, output bit h);
      logic [DATA_W-1:0] r;
      r = raw;
      h = 1'b0;
      for (int i = 0; i < m_n; i++) begin
         if (m_row[i] == (a >> COL_W) && m_col[i] == (a & ((1 << COL_W) - 1))) begin
            r[m_bit[i]] = m_spare[i];
            h = 1'b1;
         end
      end
      return r;
   endfunction

   task automatic report(input int row, input int col, input logic [DATA_W-1:0] syn);
      flt_valid = 1'b1;
      flt_addr  = ADDR_W'((row << COL_W) | col);
      flt_syn   = syn;
      tick();
      flt_valid = 1'b0;
   endtask

   task automatic model_add(input int row, input int col, input int b);
      m_row[m_n] = row; m_col[m_n] = col; m_bit[m_n] = b; m_spare[m_n] = 1'b0;
      m_n++;
   endtask

   // Full read sweep; R6 covers hit, R7/R9 the data.
   task automatic sweep(input string tag);
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         bit h;
         logic [DATA_W-1:0] e;
         acc_addr  = ADDR_W'(a);
         ram_rdata = pat(a);
         e = exp_rd(a, pat(a), h);
         if (test_mode) begin
            h = 1'b0;
            e = pat(a);
         end
         #1;
         chk(spare_hit == h, {tag, " R6 hit"}, 32'(spare_hit), 32'(h));
         chk(acc_rdata == e, {tag, " R7 rdata"}, 32'(acc_rdata), 32'(e));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(repairable == 1'b1, "R1 repairable", 32'(repairable), 1);
      chk(line_repair == 1'b0, "R1 line_repair", 32'(line_repair), 0);
      sweep("R1 empty");

      // R2 record single-bit faults
      test_mode = 1'b1;
      report(5, 1, 8'h40); model_add(5, 1, 6);
      report(5, 2, 8'h01); model_add(5, 2, 0);
      report(2, 1, 8'h80); model_add(2, 1, 7);
      report(5, 1, 8'h04); model_add(5, 1, 2);
      chk(repairable == 1'b1, "R2 four stored", 32'(repairable), 1);

      // R3 multi-bit fault
      report(7, 3, 8'h0C);
      chk(line_repair == 1'b1, "R3 line set", 32'(line_repair), 1);
      chk(repairable == 1'b1, "R3 no entry used", 32'(repairable), 1);

      // R4 duplicate on a full table
      report(5, 1, 8'h40);
      chk(repairable == 1'b1, "R4 duplicate", 32'(repairable), 1);

      // R11 zero syndrome on a full table
      report(0, 0, 8'h00);
      chk(repairable == 1'b1, "R11 zero syndrome", 32'(repairable), 1);

      // R9 test mode has no substitution
      sweep("R9 test mode");

      // R10 report in normal mode
      test_mode = 1'b0;
      report(1, 1, 8'h02);
      chk(repairable == 1'b1, "R10 normal report", 32'(repairable), 1);
      chk(line_repair == 1'b1, "R3 line sticky", 32'(line_repair), 1);

      // R6/R7 substitution with spares at 0
      sweep("R7 normal");

      // R8 writes at every address
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         logic [DATA_W-1:0] w;
         w = ~pat(a) ^ DATA_W'(a);
         acc_addr  = ADDR_W'(a);
         acc_wdata = w;
         acc_we    = 1'b1;
         tick();
         for (int i = 0; i < m_n; i++)
            if (m_row[i] == (a >> COL_W) && m_col[i] == (a & ((1 << COL_W) - 1)))
               m_spare[i] = w[m_bit[i]];
      end
      acc_we = 1'b0;
      sweep("R8 after write");

      // R9 writes in test mode leave spares alone
      test_mode = 1'b1;
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         acc_addr  = ADDR_W'(a);
         acc_wdata = ~acc_wdata;
         acc_we    = 1'b1;
         tick();
      end
      acc_we = 1'b0;
      test_mode = 1'b0;
      sweep("R9 test writes");

      // R5 overflow
      test_mode = 1'b1;
      report(1, 1, 8'h02);
      chk(repairable == 1'b0, "R5 overflow", 32'(repairable), 0);
      report(6, 0, 8'h10);
      tick();
      chk(repairable == 1'b0, "R5 sticky", 32'(repairable), 0);

      // R1 reset again
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      m_n = 0;
      test_mode = 1'b0;
      chk(repairable == 1'b1, "R1 re-reset repairable", 32'(repairable), 1);
      chk(line_repair == 1'b0, "R1 re-reset line", 32'(line_repair), 0);
      sweep("R1 cleared");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule